// File: doc/BRIEF.md
# Descriptor-Driven Histogram Engine

This block computes a histogram of single-precision floating-point samples that sit in shared memory. A host places the samples and an ascending list of bin boundaries in memory, then hands the block a single command beat on a valid/ready stream. The beat carries a transaction tag, three byte pointers (samples, boundaries, count output) and two sizes (sample count and bin count). The block checks the command. If the command is bad, it answers at once with an error status and does not touch memory.

For a good command the block makes one burst read of the samples into local storage and one burst read of the boundaries. It then places each stored sample into a bin, one sample per cycle. A sample's bin is the number of active boundaries that are less than or equal to it. The block then makes one burst write of the per-bin totals and returns one response beat that holds the tag and the status. Memory is reached through a simple request port: a word index (the byte pointer shifted right by two), a burst length and a direction. Read data returns one word per beat, and write data leaves one word per beat.

Top module: `histKernel`

## Requirements
- R1: After reset, cmdReady is 1 and rspValid, memReqValid and memWrValid are 0.
- R2: A command is taken only when cmdValid and cmdReady are both high. cmdReady then stays low until the matching response has been taken. Each command produces exactly one response, and rspId equals that command's cmdId.
- R3: The status is 1 when cmdNdata is 0 or larger than MAX_NDATA.
- R4: The status is 2 when cmdNbins is 0 or larger than MAX_NBINS.
- R5: The status is 3 when bits [1:0] of any of the three pointers are nonzero. When several checks fail, the smallest failing code is reported. The status is 0 when every check passes.
- R6: A command with a nonzero status produces no memory request and no write beat before its response.
- R7: For a good command, the first request is a read (memReqWrite=0) at word index cmdSampleAddr>>2 with length cmdNdata. The second request is a read at cmdEdgeAddr>>2 with length cmdNbins-1. The second request is left out when cmdNbins is 1.
- R8: A sample falls in bin k, where k is the number of the first cmdNbins-1 boundaries that are less than or equal to the sample under IEEE-754 single-precision ordering. All negative values order below all non-negative values, and a more negative value orders lower.
- R9: The final request is a write (memReqWrite=1) at word index cmdCountAddr>>2 with length cmdNbins. It is followed by cmdNbins write beats, bin 0 first, each holding a 32-bit unsigned total. A beat advances only when memWrReady is high.
- R10: All totals are cleared when a command is accepted, so the totals from one command never carry into the next.
- R11: While memReqValid is high and memReqReady is low, the request fields do not change. While rspValid is high and rspReady is low, rspId and rspStatus do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdValid | input | 1 | A command beat is offered |
| cmdReady | output | 1 | The block can take a command |
| cmdId | input | ID_W | Transaction tag |
| cmdSampleAddr | input | ADDR_W | Byte pointer to the samples |
| cmdEdgeAddr | input | ADDR_W | Byte pointer to the bin boundaries |
| cmdNdata | input | LEN_W | Number of samples |
| cmdNbins | input | LEN_W | Number of bins |
| cmdCountAddr | input | ADDR_W | Byte pointer to the count output |
| rspValid | output | 1 | A response beat is offered |
| rspReady | input | 1 | The host takes the response |
| rspId | output | ID_W | Echoed tag |
| rspStatus | output | 2 | 0 ok, 1 bad sample count, 2 bad bin count, 3 misaligned pointer |
| memReqValid | output | 1 | A burst request is offered |
| memReqReady | input | 1 | Memory takes the request |
| memReqWrite | output | 1 | 1 = write burst, 0 = read burst |
| memReqIdx | output | ADDR_W-2 | Word index of the burst start |
| memReqLen | output | LEN_W | Burst length in words |
| memRdValid | input | 1 | A read data beat is present |
| memRdData | input | DATA_W | Read data word |
| memWrValid | output | 1 | A write data beat is offered |
| memWrReady | input | 1 | Memory takes the write beat |
| memWrData | output | DATA_W | Write data word |

## Verification
A wrong internal state shows at the ports within one burst. A misbuilt sample or boundary store gives wrong totals in the write beats. A bad ordering key moves samples between neighbouring bins, and a boundary list that is mixed negative and positive exposes it. Totals that are not cleared show up as inflated counts on the next command. A validation fault shows in the next response, or as a memory request that should not be there before that response. A sequencing fault shows as a wrong index or length on a request, or as a request that is missing or extra.

// File: rtl/histPkg.sv
package histPkg;

  typedef struct packed {
    logic clrCounts;
    logic sampleWe;
    logic edgeWe;
    logic binEn;
  } dpStrobe_t;

  typedef enum logic [1:0] {
    ST_OK        = 2'd0,
    ST_BAD_NDATA = 2'd1,
    ST_BAD_NBINS = 2'd2,
    ST_MISALIGN  = 2'd3
  } histStatus_t;

  // Map a single-precision value onto an unsigned key with the same order.
  function automatic logic [31:0] orderKey(input logic [31:0] f);
    return f[31] ? ~f : {1'b1, f[30:0]};
  endfunction

endpackage

// File: rtl/histDatapath.sv
module histDatapath
  import histPkg::*;
#(
  parameter int LEN_W     = 16,
  parameter int DATA_W    = 32,
  parameter int MAX_NDATA = 256,
  parameter int MAX_NBINS = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [LEN_W-1:0]  beatIdx,
  input  logic [LEN_W-1:0]  nEdges,
  input  logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] wrData
);
  localparam int SIDX_W = $clog2(MAX_NDATA);
  localparam int CIDX_W = $clog2(MAX_NBINS);
  localparam int CNT_W  = $clog2(MAX_NDATA + 1);
  localparam int NEDGE  = MAX_NBINS - 1;

  logic [DATA_W-1:0] sampleMem [MAX_NDATA];
  logic [DATA_W-1:0] edgeMem   [NEDGE];
  logic [CNT_W-1:0]  counts    [MAX_NBINS];
  logic [SIDX_W-1:0] sIdx;
  logic [CIDX_W-1:0] cIdx;
  logic [CIDX_W-1:0] binSel;
  logic [31:0]       sKey;
  logic              unusedIdxBits;

  assign sIdx = beatIdx[SIDX_W-1:0];
  assign cIdx = beatIdx[CIDX_W-1:0];
  assign unusedIdxBits = ^beatIdx[LEN_W-1:SIDX_W];

  always_ff @(posedge clk) begin
    if (strobe.sampleWe) sampleMem[sIdx] <= rdData;
    if (strobe.edgeWe)   edgeMem[cIdx]   <= rdData;
  end

  // Count how many active boundaries lie at or below the current sample.
  always_comb begin
    sKey   = orderKey(sampleMem[sIdx][31:0]);
    binSel = '0;
    for (int i = 0; i < NEDGE; i++) begin
      if (LEN_W'(i) < nEdges && sKey >= orderKey(edgeMem[i][31:0]))
        binSel = binSel + CIDX_W'(1);
    end
  end

  generate
    for (genvar b = 0; b < MAX_NBINS; b++) begin : g_bin
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                                          counts[b] <= '0;
        else if (strobe.clrCounts)                          counts[b] <= '0;
        else if (strobe.binEn && binSel == CIDX_W'(b))      counts[b] <= counts[b] + CNT_W'(1);
      end
    end
  endgenerate

  assign wrData = DATA_W'(counts[cIdx]);

endmodule

// File: rtl/histCtrl.sv
module histCtrl
  import histPkg::*;
#(
  parameter int ID_W      = 8,
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 16,
  parameter int MAX_NDATA = 256,
  parameter int MAX_NBINS = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic [ID_W-1:0]   cmdId,
  input  logic [ADDR_W-1:0] cmdSampleAddr,
  input  logic [ADDR_W-1:0] cmdEdgeAddr,
  input  logic [LEN_W-1:0]  cmdNdata,
  input  logic [LEN_W-1:0]  cmdNbins,
  input  logic [ADDR_W-1:0] cmdCountAddr,
  output logic              rspValid,
  input  logic              rspReady,
  output logic [ID_W-1:0]   rspId,
  output logic [1:0]        rspStatus,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic              memReqWrite,
  output logic [ADDR_W-3:0] memReqIdx,
  output logic [LEN_W-1:0]  memReqLen,
  input  logic              memRdValid,
  output logic              memWrValid,
  input  logic              memWrReady,
  output dpStrobe_t         strobe,
  output logic [LEN_W-1:0]  beatIdx,
  output logic [LEN_W-1:0]  nEdges
);
  typedef enum logic [3:0] {
    S_IDLE, S_CHECK, S_RDS_REQ, S_RDS_DAT, S_RDE_REQ, S_RDE_DAT,
    S_BIN, S_WR_REQ, S_WR_DAT, S_RESP
  } state_t;

  localparam logic [LEN_W-1:0] ND_MAX = LEN_W'(MAX_NDATA);
  localparam logic [LEN_W-1:0] NB_MAX = LEN_W'(MAX_NBINS);
  localparam logic [LEN_W-1:0] ONE    = LEN_W'(1);

  state_t            state;
  histStatus_t       statusR, chkCode;
  logic [ID_W-1:0]   idR;
  logic [ADDR_W-1:0] sAddrR, eAddrR, cAddrR;
  logic [LEN_W-1:0]  nDataR, nBinsR, beat;
  logic              lastData, lastEdge, lastCnt;

  always_comb begin
    if (nDataR == '0 || nDataR > ND_MAX)                         chkCode = ST_BAD_NDATA;
    else if (nBinsR == '0 || nBinsR > NB_MAX)                    chkCode = ST_BAD_NBINS;
    else if (|{sAddrR[1:0], eAddrR[1:0], cAddrR[1:0]})           chkCode = ST_MISALIGN;
    else                                                         chkCode = ST_OK;
  end

  assign lastData = (beat == nDataR - ONE);
  assign lastEdge = (beat == nBinsR - LEN_W'(2));
  assign lastCnt  = (beat == nBinsR - ONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      statusR <= ST_OK;
      idR     <= '0;
      sAddrR  <= '0;
      eAddrR  <= '0;
      cAddrR  <= '0;
      nDataR  <= '0;
      nBinsR  <= '0;
      beat    <= '0;
    end else begin
      case (state)
        S_IDLE: if (cmdValid) begin
          idR    <= cmdId;
          sAddrR <= cmdSampleAddr;
          eAddrR <= cmdEdgeAddr;
          cAddrR <= cmdCountAddr;
          nDataR <= cmdNdata;
          nBinsR <= cmdNbins;
          state  <= S_CHECK;
        end
        S_CHECK: begin
          statusR <= chkCode;
          beat    <= '0;
          state   <= (chkCode != ST_OK) ? S_RESP : S_RDS_REQ;
        end
        S_RDS_REQ: if (memReqReady) state <= S_RDS_DAT;
        S_RDS_DAT: if (memRdValid) begin
          beat <= lastData ? '0 : beat + ONE;
          if (lastData) state <= (nBinsR == ONE) ? S_BIN : S_RDE_REQ;
        end
        S_RDE_REQ: if (memReqReady) state <= S_RDE_DAT;
        S_RDE_DAT: if (memRdValid) begin
          beat <= lastEdge ? '0 : beat + ONE;
          if (lastEdge) state <= S_BIN;
        end
        S_BIN: begin
          beat <= lastData ? '0 : beat + ONE;
          if (lastData) state <= S_WR_REQ;
        end
        S_WR_REQ: if (memReqReady) state <= S_WR_DAT;
        S_WR_DAT: if (memWrReady) begin
          beat <= lastCnt ? '0 : beat + ONE;
          if (lastCnt) state <= S_RESP;
        end
        S_RESP: if (rspReady) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    memReqIdx = sAddrR[ADDR_W-1:2];
    memReqLen = nDataR;
    case (state)
      S_RDE_REQ: begin memReqIdx = eAddrR[ADDR_W-1:2]; memReqLen = nBinsR - ONE; end
      S_WR_REQ:  begin memReqIdx = cAddrR[ADDR_W-1:2]; memReqLen = nBinsR;       end
      default: ;
    endcase
  end

  assign cmdReady    = (state == S_IDLE);
  assign rspValid    = (state == S_RESP);
  assign rspId       = idR;
  assign rspStatus   = statusR;
  assign memReqValid = (state == S_RDS_REQ) || (state == S_RDE_REQ) || (state == S_WR_REQ);
  assign memReqWrite = (state == S_WR_REQ);
  assign memWrValid  = (state == S_WR_DAT);

  assign strobe.clrCounts = (state == S_IDLE) && cmdValid;
  assign strobe.sampleWe  = (state == S_RDS_DAT) && memRdValid;
  assign strobe.edgeWe    = (state == S_RDE_DAT) && memRdValid;
  assign strobe.binEn     = (state == S_BIN);
  assign beatIdx          = beat;
  assign nEdges           = nBinsR - ONE;

endmodule

// File: rtl/histKernel.sv
module histKernel
  import histPkg::*;
#(
  parameter int ID_W      = 8,
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 16,
  parameter int DATA_W    = 32,
  parameter int MAX_NDATA = 256,
  parameter int MAX_NBINS = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic [ID_W-1:0]   cmdId,
  input  logic [ADDR_W-1:0] cmdSampleAddr,
  input  logic [ADDR_W-1:0] cmdEdgeAddr,
  input  logic [LEN_W-1:0]  cmdNdata,
  input  logic [LEN_W-1:0]  cmdNbins,
  input  logic [ADDR_W-1:0] cmdCountAddr,
  output logic              rspValid,
  input  logic              rspReady,
  output logic [ID_W-1:0]   rspId,
  output logic [1:0]        rspStatus,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic              memReqWrite,
  output logic [ADDR_W-3:0] memReqIdx,
  output logic [LEN_W-1:0]  memReqLen,
  input  logic              memRdValid,
  input  logic [DATA_W-1:0] memRdData,
  output logic              memWrValid,
  input  logic              memWrReady,
  output logic [DATA_W-1:0] memWrData
);
  dpStrobe_t        strobe;
  logic [LEN_W-1:0] beatIdx;
  logic [LEN_W-1:0] nEdges;

  histCtrl #(
    .ID_W(ID_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W),
    .MAX_NDATA(MAX_NDATA), .MAX_NBINS(MAX_NBINS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdId(cmdId),
    .cmdSampleAddr(cmdSampleAddr), .cmdEdgeAddr(cmdEdgeAddr),
    .cmdNdata(cmdNdata), .cmdNbins(cmdNbins), .cmdCountAddr(cmdCountAddr),
    .rspValid(rspValid), .rspReady(rspReady), .rspId(rspId), .rspStatus(rspStatus),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqWrite(memReqWrite),
    .memReqIdx(memReqIdx), .memReqLen(memReqLen), .memRdValid(memRdValid),
    .memWrValid(memWrValid), .memWrReady(memWrReady),
    .strobe(strobe), .beatIdx(beatIdx), .nEdges(nEdges)
  );

  histDatapath #(
    .LEN_W(LEN_W), .DATA_W(DATA_W),
    .MAX_NDATA(MAX_NDATA), .MAX_NBINS(MAX_NBINS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .beatIdx(beatIdx),
    .nEdges(nEdges), .rdData(memRdData), .wrData(memWrData)
  );

endmodule

// File: rtl/histKernelChk.sv
module histKernelChk #(
  parameter int ID_W   = 8,
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdValid,
  input logic              cmdReady,
  input logic              rspValid,
  input logic              rspReady,
  input logic [ID_W-1:0]   rspId,
  input logic [1:0]        rspStatus,
  input logic              memReqValid,
  input logic              memReqReady,
  input logic              memReqWrite,
  input logic [ADDR_W-3:0] memReqIdx,
  input logic [LEN_W-1:0]  memReqLen,
  input logic              memWrValid
);
  logic sawMem;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     sawMem <= 1'b0;
    else if (cmdValid && cmdReady) sawMem <= 1'b0;
    else if (memReqValid || memWrValid) sawMem <= 1'b1;
  end

  // R11
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspReady |=> rspValid && $stable(rspId) && $stable(rspStatus));

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid && $stable(memReqIdx)
      && $stable(memReqLen) && $stable(memReqWrite));

  // R2
  busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid || memReqValid || memWrValid) |-> !cmdReady);

  // R6
  err_no_mem_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspStatus != 2'd0 |-> !sawMem);

  // R7
  req_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> memReqLen != '0);

  // R9
  wr_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWrValid |-> !memReqValid && !rspValid);

endmodule

bind histKernel histKernelChk #(.ID_W(ID_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (.*);

// File: tb/histKernel_tb.sv
module histKernel_tb;
  localparam int ID_W = 8, ADDR_W = 32, LEN_W = 16, DATA_W = 32;
  localparam int MAX_NDATA = 256, MAX_NBINS = 32;

  logic clk = 1'b0, rstN = 1'b0;
  logic cmdValid = 1'b0, cmdReady;
  logic [ID_W-1:0] cmdId = '0;
  logic [ADDR_W-1:0] cmdSampleAddr = '0, cmdEdgeAddr = '0, cmdCountAddr = '0;
  logic [LEN_W-1:0] cmdNdata = '0, cmdNbins = '0;
  logic rspValid, rspReady = 1'b0;
  logic [ID_W-1:0] rspId;
  logic [1:0] rspStatus;
  logic memReqValid, memReqReady = 1'b0, memReqWrite;
  logic [ADDR_W-3:0] memReqIdx;
  logic [LEN_W-1:0] memReqLen;
  logic memRdValid = 1'b0;
  logic [DATA_W-1:0] memRdData = '0;
  logic memWrValid, memWrReady = 1'b0;
  logic [DATA_W-1:0] memWrData;

  always #5 clk = ~clk;

  histKernel u_dut (.*);

  int checks = 0, errors = 0;
  logic [31:0] mem [0:1023];
  int logN = 0;
  logic [31:0] logIdx [0:7];
  logic [31:0] logLen [0:7];
  logic        logWr  [0:7];
  logic        reqUnstable = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Memory model: stalls each request once, gaps reads, throttles writes.
  initial begin
    @(posedge rstN);
    forever begin
      @(negedge clk);
      if (memReqValid) begin
        logic [31:0] i0, l0; logic w0;
        i0 = 32'(memReqIdx); l0 = 32'(memReqLen); w0 = memReqWrite;
        @(negedge clk);
        if (!memReqValid || 32'(memReqIdx) != i0 || 32'(memReqLen) != l0 || memReqWrite != w0)
          reqUnstable = 1'b1;
        memReqReady = 1'b1;
        if (logN < 8) begin logIdx[logN] = i0; logLen[logN] = l0; logWr[logN] = w0; end
        logN++;
        @(negedge clk);
        memReqReady = 1'b0;
        if (!w0) begin
          for (int i = 0; i < int'(l0); i++) begin
            memRdValid = 1'b1;
            memRdData  = mem[(i0 + 32'(i)) % 1024];
            @(negedge clk);
            if (i % 2 == 0) begin memRdValid = 1'b0; @(negedge clk); end
          end
          memRdValid = 1'b0;
        end else begin
          int wc, k;
          wc = 0; k = 0;
          while (wc < int'(l0)) begin
            memWrReady = (k % 3 != 2);
            if (memWrValid && memWrReady) begin
              mem[(i0 + 32'(wc)) % 1024] = memWrData;
              wc++;
            end
            k++;
            @(negedge clk);
          end
          memWrReady = 1'b0;
        end
      end
    end
  end

  task automatic runCmd(input logic [7:0] id, input logic [31:0] sA, input logic [31:0] eA,
                        input logic [15:0] nd, input logic [15:0] nb, input logic [31:0] cA,
                        output logic [7:0] gotId, output logic [1:0] gotSt);
    int cnt;
    logN = 0; reqUnstable = 1'b0;
    @(negedge clk);
    cmdValid = 1'b1; cmdId = id; cmdSampleAddr = sA; cmdEdgeAddr = eA;
    cmdNdata = nd; cmdNbins = nb; cmdCountAddr = cA;
    while (!cmdReady) @(negedge clk);
    @(negedge clk);
    cmdValid = 1'b0;
    chk("R2 busy after accept", 32'(cmdReady), 32'd0);
    cnt = 0;
    while (!rspValid && cnt < 20000) begin @(negedge clk); cnt++; end
    gotId = rspId; gotSt = rspStatus;
    @(negedge clk); @(negedge clk);
    chk("R11 response held", {rspValid, 22'd0, rspStatus, rspId}, {1'b1, 22'd0, gotSt, gotId});
    chk("R2 no accept while response pending", 32'(cmdReady), 32'd0);
    rspReady = 1'b1;
    @(negedge clk);
    rspReady = 1'b0;
    chk("R2 one response", 32'(rspValid), 32'd0);
    chk("R11 request held", 32'(reqUnstable), 32'd0);
  endtask

  task automatic errCase(input string req, input logic [31:0] sA, input logic [31:0] eA,
                         input logic [15:0] nd, input logic [15:0] nb, input logic [31:0] cA,
                         input logic [1:0] expSt);
    logic [7:0] id; logic [1:0] st;
    mem[900] = 32'h1234_5678;
    runCmd(8'h5A, sA, eA, nd, nb, cA, id, st);
    chk({req, " status"}, 32'(st), 32'(expSt));
    chk("R2 id echo", 32'(id), 32'h5A);
    chk("R6 no memory request", 32'(logN), 32'd0);
    chk("R6 memory untouched", mem[900], 32'h1234_5678);
  endtask

  task automatic testMain();
    logic [7:0] id; logic [1:0] st;
    logic [31:0] smp [10];
    logic [31:0] expC [4];
    smp = '{32'hC1200000, 32'hBF000000, 32'h00000000, 32'h3F000000, 32'h3F800000,
            32'h3FC00000, 32'h40000000, 32'h40400000, 32'h41200000, 32'hC0000000};
    for (int i = 0; i < 10; i++) mem[64 + i] = smp[i];
    mem[128] = 32'h00000000; mem[129] = 32'h3F800000; mem[130] = 32'h40000000;
    for (int i = 0; i < 4; i++) mem[192 + i] = 32'hDEAD_BEEF;
    runCmd(8'h11, 32'h100, 32'h200, 16'd10, 16'd4, 32'h300, id, st);
    chk("R5 status ok", 32'(st), 32'd0);
    chk("R2 id echo", 32'(id), 32'h11);
    chk("R7 request count", 32'(logN), 32'd3);
    chk("R7 sample read", {logIdx[0][30:0], logWr[0]}, {31'd64, 1'b0});
    chk("R7 sample len", logLen[0], 32'd10);
    chk("R7 edge read", {logIdx[1][30:0], logWr[1]}, {31'd128, 1'b0});
    chk("R7 edge len", logLen[1], 32'd3);
    chk("R9 count write", {logIdx[2][30:0], logWr[2]}, {31'd192, 1'b1});
    chk("R9 count len", logLen[2], 32'd4);
    expC = '{32'd3, 32'd2, 32'd2, 32'd3};
    for (int i = 0; i < 4; i++) chk("R8 R9 bin total", mem[192 + i], expC[i]);
    // R10: second command on the same region must not accumulate
    mem[64] = 32'h3F000000; mem[65] = 32'h3F000000;
    runCmd(8'h12, 32'h100, 32'h200, 16'd2, 16'd4, 32'h300, id, st);
    expC = '{32'd0, 32'd2, 32'd0, 32'd0};
    for (int i = 0; i < 4; i++) chk("R10 totals cleared", mem[192 + i], expC[i]);
  endtask

  task automatic testNegative();
    logic [7:0] id; logic [1:0] st;
    mem[300] = 32'hC0000000; mem[301] = 32'hBF400000; mem[302] = 32'hBF000000; mem[303] = 32'h00000000;
    mem[310] = 32'hBF800000; mem[311] = 32'hBF000000;
    runCmd(8'h21, 32'd1200, 32'd1240, 16'd4, 16'd3, 32'd1280, id, st);
    chk("R8 negative status", 32'(st), 32'd0);
    chk("R8 negative bin0", mem[320], 32'd1);
    chk("R8 negative bin1", mem[321], 32'd1);
    chk("R8 negative bin2", mem[322], 32'd2);
  endtask

  task automatic testOneBin();
    logic [7:0] id; logic [1:0] st;
    mem[400] = 32'h3F800000; mem[401] = 32'hBF800000; mem[402] = 32'h41200000;
    mem[410] = 32'hFFFF_FFFF;
    runCmd(8'h31, 32'd1600, 32'd2000, 16'd3, 16'd1, 32'd1640, id, st);
    chk("R7 single bin skips edge read", 32'(logN), 32'd2);
    chk("R9 single bin write", {logIdx[1][30:0], logWr[1]}, {31'd410, 1'b1});
    chk("R9 single bin total", mem[410], 32'd3);
  endtask

  task automatic testMax();
    logic [7:0] id; logic [1:0] st;
    for (int i = 0; i < MAX_NDATA; i++) mem[256 + i] = 32'h3F000000;
    for (int i = 0; i < MAX_NBINS - 1; i++) mem[600 + i] = 32'h3F800000;
    for (int i = 0; i < MAX_NBINS; i++) mem[700 + i] = 32'hFFFF_FFFF;
    runCmd(8'h41, 32'd1024, 32'd2400, 16'(MAX_NDATA), 16'(MAX_NBINS), 32'd2800, id, st);
    chk("R3 R4 max sizes accepted", 32'(st), 32'd0);
    chk("R9 max bin0", mem[700], 32'(MAX_NDATA));
    chk("R9 max last bin", mem[700 + MAX_NBINS - 1], 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {31'd0, cmdReady}, 32'd1);
    chk("R1 reset idle", {29'd0, rspValid, memReqValid, memWrValid}, 32'd0);
    rstN = 1'b1;
    testMain();
    testNegative();
    testOneBin();
    testMax();
    errCase("R3 zero ndata", 32'h100, 32'h200, 16'd0, 16'd4, 32'h300, 2'd1);
    errCase("R3 ndata over max", 32'h100, 32'h200, 16'(MAX_NDATA + 1), 16'd4, 32'h300, 2'd1);
    errCase("R4 zero nbins", 32'h100, 32'h200, 16'd5, 16'd0, 32'h300, 2'd2);
    errCase("R4 nbins over max", 32'h100, 32'h200, 16'd5, 16'(MAX_NBINS + 1), 32'h300, 2'd2);
    errCase("R5 misaligned edge", 32'h100, 32'h201, 16'd5, 16'd4, 32'h300, 2'd3);
    errCase("R5 misaligned count", 32'h100, 32'h200, 16'd5, 16'd4, 32'h302, 2'd3);
    errCase("R5 priority all bad", 32'h101, 32'h200, 16'd0, 16'd0, 32'h300, 2'd1);
    errCase("R5 priority bins and align", 32'h103, 32'h200, 16'd5, 16'd0, 32'h300, 2'd2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule